// File: doc/BRIEF.md
# Masked Interrupt Flag Controller

This block collects single-cycle event strobes, for example counter underflows, into a latched flag register. It gates those flags with an interrupt mask and drives one active-low interrupt request line. Software sees one status register. A status read returns every pending flag and a summary bit that shows the request state. The same read clears all flags and the request at the next clock edge. Mask writes use set/clear semantics: bit 7 of the write data chooses set or clear, and every lower bit written as 1 names a mask bit to change.

Timing is exact to the clock. A masked-in event raises the request one clock after it arrives. A status read in the same clock as the event reports the event but stops the request. Once the request is latched, clearing mask bits does not drop it. Only a status read releases it. If software sets a mask bit while the matching flag is already pending, the request is raised from that pending flag.

Top module: `irqc_ctrl`

## Requirements
- R1: After reset, every flag, every mask bit and the request are clear. `rd_data` reads 0x00 and `irq_n` is 1.
- R2: An event strobe on `evt_i[i]` sets status bit i. Bit 0 is source 0 and bit 1 is source 1. `rd_data` shows the pending flags, including events in the current cycle. Bits from NUM_SRC to 6 read 0.
- R3: If `evt_i[i]` is high in cycle t, mask bit i is set and `rd_stb` is low, then `irq_n` is 0 from cycle t+1. Status bit 7 (the summary bit) reads 1 from cycle t+1.
- R4: A read in the same cycle as an event returns the event's flag with bit 7 at 0. No request follows, and the flag reads 0 in the next cycle.
- R5: A read clears all flags and the request. In the cycle after the read, `rd_data` is 0x00 unless a new event arrives, and `irq_n` is 1.
- R6: Once the request is latched, a mask write that clears the mask bits leaves `irq_n` at 0 until a read.
- R7: A mask write in cycle c that sets a mask bit whose flag is already pending makes `irq_n` 0 from cycle c+2.
- R8: For a mask write, bit 7 = 1 sets and bit 7 = 0 clears each mask bit i whose write data bit i is 1. Mask bits written with 0 keep their value.
- R9: A flag whose mask bit is clear never drives `irq_n` low.
- R10: Flags accumulate until a read. With the mask holding only bit 1, an event on source 0 and then on source 1 reads 0x01, then 0x03 in the cycle of the second event, then 0x83.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | One-cycle event strobes, one per source |
| rd_stb | input | 1 | Status read strobe; clears flags and request at the next edge |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask write data; bit 7 selects set or clear |
| rd_data | output | 8 | Status read data: flags in low bits, request in bit 7 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Each result has a fixed due cycle:
- Flag bits show on `rd_data` in the same cycle as their event.
- Bit 7 and `irq_n` change one cycle after a masked event or a read.
- The request follows a mask write that uncovers a pending flag two cycles after the write.

The bench drives inputs just after the falling edge and samples one time unit later. Each sample therefore reflects only the edges already passed, and each check names the exact cycle counted from its stimulus. The read-around-event cases read one cycle before, in the same cycle as, and one cycle after the event. They check both the returned data and whether the request appears.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int STAT_W  = 8;
   localparam int SUM_BIT = STAT_W - 1;
   localparam int MAX_SRC = STAT_W - 1;
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
   parameter int NUM_SRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               rd_stb,
   output logic [NUM_SRC-1:0] flag_q,
   output logic [NUM_SRC-1:0] pend_o
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag_q[i] <= 1'b0;
         else if (rd_stb) flag_q[i] <= 1'b0;
         else if (evt_i[i]) flag_q[i] <= 1'b1;
      end

      // R2: an unread event is held as a flag
      a_r2_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_i[i] && !rd_stb) |=> flag_q[i]);
      // R5: a read clears the flag
      a_r5_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
         rd_stb |=> !flag_q[i]);
   end

   assign pend_o = flag_q | evt_i;
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
   parameter int NUM_SRC = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [irqc_pkg::STAT_W-1:0]  wdata,
   output logic [NUM_SRC-1:0]           mask_q
);
   import irqc_pkg::*;

   logic set_sel;
   assign set_sel = wdata[SUM_BIT];

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                mask_q[i] <= 1'b0;
         else if (we && wdata[i])   mask_q[i] <= set_sel;
      end

      // R8: a selected bit takes the set/clear choice
      a_r8_mask_select: assert property (@(posedge clk) disable iff (!rst_n)
         (we && wdata[i]) |=> (mask_q[i] == $past(wdata[SUM_BIT])));
      // R8: an unselected bit keeps its value
      a_r8_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && wdata[i]) |=> $stable(mask_q[i]));
   end

   if (NUM_SRC < MAX_SRC) begin : g_spare
      logic unused_wbits;
      assign unused_wbits = ^wdata[MAX_SRC-1:NUM_SRC];
   end
endmodule

// File: rtl/irqc_req.sv
module irqc_req #(
   parameter int NUM_SRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic [NUM_SRC-1:0] mask_i,
   input  logic               rd_stb,
   output logic               req_q
);
   logic hit;
   assign hit = |(pend_i & mask_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      req_q <= 1'b0;
      else if (rd_stb) req_q <= 1'b0;
      else if (hit)    req_q <= 1'b1;
   end

   // R3: a masked pending flag raises the request next cycle
   a_r3_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb && |(pend_i & mask_i)) |=> req_q);
   // R4/R5: a read always drops the request
   a_r5_read_drops: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> !req_q);
   // R6: without a read the request is held
   a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !rd_stb) |=> req_q);
   // R9: the request never rises without a masked source
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q) |-> $past(|(pend_i & mask_i)));
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl #(
   parameter int NUM_SRC = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SRC-1:0]          evt_i,
   input  logic                        rd_stb,
   input  logic                        mask_we,
   input  logic [irqc_pkg::STAT_W-1:0] mask_wdata,
   output logic [irqc_pkg::STAT_W-1:0] rd_data,
   output logic                        irq_n
);
   import irqc_pkg::*;

   initial begin
      assert (NUM_SRC >= 1 && NUM_SRC <= MAX_SRC)
         else $error("NUM_SRC must lie in 1..%0d", MAX_SRC);
   end

   logic [NUM_SRC-1:0] flag_q;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] mask_q;
   logic               req_q;

   irqc_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_stb(rd_stb),
      .flag_q(flag_q), .pend_o(pend));

   irqc_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(mask_wdata),
      .mask_q(mask_q));

   irqc_req #(.NUM_SRC(NUM_SRC)) u_req (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask_q),
      .rd_stb(rd_stb), .req_q(req_q));

   always_comb begin
      rd_data                 = '0;
      rd_data[NUM_SRC-1:0]    = pend;
      rd_data[SUM_BIT]        = req_q;
   end

   assign irq_n = ~req_q;

   // R1: nothing is pending in the first cycle after reset
   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_n && flag_q == '0));
   // R2: status bits follow the flags in the same cycle
   a_r2_status_view: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[NUM_SRC-1:0] & flag_q) == flag_q);
   // R3: the line and the summary bit agree
   a_r3_line_matches: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[SUM_BIT] == !irq_n);
endmodule

// File: tb/irqc_ctrl_test.sv
module irqc_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] evt_i = '0;
   logic       rd_stb = 1'b0;
   logic       mask_we = 1'b0;
   logic [7:0] mask_wdata = '0;
   logic [7:0] rd_data;
   logic       irq_n;

   int checks = 0;
   int errors = 0;

   irqc_ctrl #(.NUM_SRC(2)) uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_stb(rd_stb),
      .mask_we(mask_we), .mask_wdata(mask_wdata),
      .rd_data(rd_data), .irq_n(irq_n));

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [7:0] act_d, input logic [7:0] exp_d,
                      input logic act_i, input logic exp_i);
      checks++;
      if (act_d !== exp_d || act_i !== exp_i) begin
         errors++;
         $display("FAIL %s: rd_data=%02h irq_n=%b expected rd_data=%02h irq_n=%b",
                  req, act_d, act_i, exp_d, exp_i);
      end
   endtask

   // one cycle: drive after falling edge, settle, caller samples
   task automatic step(input logic [1:0] e, input logic r, input logic w, input logic [7:0] d);
      @(negedge clk);
      evt_i = e; rd_stb = r; mask_we = w; mask_wdata = d;
      #1;
   endtask

   task automatic idle();
      step(2'b00, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; evt_i = '0; rd_stb = 1'b0; mask_we = 1'b0; mask_wdata = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      idle();
      chk("R1 reset idle", rd_data, 8'h00, irq_n, 1'b1);
   endtask

   task automatic t_event_irq();
      do_reset();
      step(2'b00, 1'b0, 1'b1, 8'h81);           // set mask bit0
      step(2'b01, 1'b0, 1'b0, 8'h00);           // event at t
      chk("R2 event visible same cycle", rd_data, 8'h01, irq_n, 1'b1);
      idle();                                   // t+1
      chk("R3 irq one cycle after event", rd_data, 8'h81, irq_n, 1'b0);
      step(2'b00, 1'b1, 1'b0, 8'h00);           // read
      chk("R5 read returns summary", rd_data, 8'h81, irq_n, 1'b0);
      idle();
      chk("R5 read clears all", rd_data, 8'h00, irq_n, 1'b1);
   endtask

   task automatic t_read_before();
      do_reset();
      step(2'b00, 1'b0, 1'b1, 8'h81);
      step(2'b00, 1'b1, 1'b0, 8'h00);           // read at t-1
      chk("R5 read at t-1 sees nothing", rd_data, 8'h00, irq_n, 1'b1);
      step(2'b01, 1'b0, 1'b0, 8'h00);           // event at t
      idle();
      chk("R3 irq taken after read at t-1", rd_data, 8'h81, irq_n, 1'b0);
   endtask

   task automatic t_read_same();
      do_reset();
      step(2'b00, 1'b0, 1'b1, 8'h81);
      step(2'b01, 1'b1, 1'b0, 8'h00);           // read with event
      chk("R4 read at t returns flag", rd_data, 8'h01, irq_n, 1'b1);
      idle();
      chk("R4 no irq after same-cycle read", rd_data, 8'h00, irq_n, 1'b1);
      idle();
      chk("R4 still no irq", rd_data, 8'h00, irq_n, 1'b1);
   endtask

   task automatic t_mask_clear_hold();
      do_reset();
      step(2'b00, 1'b0, 1'b1, 8'h81);
      step(2'b01, 1'b0, 1'b0, 8'h00);
      step(2'b00, 1'b0, 1'b1, 8'h01);           // clear mask bit0
      chk("R6 irq latched", rd_data, 8'h81, irq_n, 1'b0);
      idle(); idle();
      chk("R6 mask clear does not release", rd_data, 8'h81, irq_n, 1'b0);
      step(2'b00, 1'b1, 1'b0, 8'h00);
      idle();
      chk("R6 only read releases", rd_data, 8'h00, irq_n, 1'b1);
   endtask

   task automatic t_late_mask();
      do_reset();
      step(2'b01, 1'b0, 1'b0, 8'h00);           // unmasked event
      idle(); idle();
      chk("R9 unmasked flag no irq", rd_data, 8'h01, irq_n, 1'b1);
      step(2'b00, 1'b0, 1'b1, 8'h81);           // write at c
      idle();                                   // c+1
      chk("R7 not yet at c+1", rd_data, 8'h01, irq_n, 1'b1);
      idle();                                   // c+2
      chk("R7 irq at c+2 from pending flag", rd_data, 8'h81, irq_n, 1'b0);
   endtask

   task automatic t_set_clear();
      do_reset();
      step(2'b00, 1'b0, 1'b1, 8'h81);           // set bit0
      step(2'b00, 1'b0, 1'b1, 8'h82);           // set bit1, bit0 kept
      step(2'b00, 1'b0, 1'b1, 8'h02);           // clear bit1
      step(2'b10, 1'b0, 1'b0, 8'h00);           // source1 event
      idle(); idle();
      chk("R8 cleared bit1 gives no irq", rd_data, 8'h02, irq_n, 1'b1);
      step(2'b01, 1'b0, 1'b0, 8'h00);           // source0 event
      idle();
      chk("R8 bit0 kept by later write", rd_data, 8'h83, irq_n, 1'b0);
   endtask

   task automatic t_cascade();
      do_reset();
      step(2'b00, 1'b0, 1'b1, 8'h82);           // mask = bit1 only
      step(2'b01, 1'b0, 1'b0, 8'h00);
      idle();
      chk("R10 first status 01", rd_data, 8'h01, irq_n, 1'b1);
      step(2'b10, 1'b0, 1'b0, 8'h00);
      chk("R10 second status 03", rd_data, 8'h03, irq_n, 1'b1);
      idle();
      chk("R10 third status 83", rd_data, 8'h83, irq_n, 1'b0);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_event_irq();
      t_read_before();
      t_read_same();
      t_mask_clear_hold();
      t_late_mask();
      t_set_clear();
      t_cascade();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule